// File: doc/BRIEF.md
# Parallel Translation and Direct-Mapped Cache Lookup

This block serves a load request by translating a 32-bit virtual address and reading a small direct-mapped data cache in the same cycle. The cache index is taken only from bits inside the 4 KB page offset. Because translation never changes those bits, the cache array read does not wait for the translation. At the same time, an 8-entry fully associative translation buffer matches the 20-bit virtual page number and returns a 20-bit physical frame number. At the output, that frame number is compared with the physical tag held in the indexed cache line.

Each lookup answers one clock after the request. The answer carries a translation-miss flag, a cache-hit flag, the translated physical address, the full 32-bit word and the byte chosen by the two lowest address bits. Translation entries and cache lines are loaded through two separate fill ports. Fill ports and lookups must not be active in the same cycle. Misses are only reported. Page walking and refill sequencing belong to the surrounding logic.

Top module: `xlat_dcache_lookup`

## Requirements
- R1: Synchronous active-high reset clears every translation entry, every cache line's valid bit, the round-robin fill pointer and `rsp_valid`. After reset, every lookup reports a translation miss. A frame loaded after reset still reports a cache miss until its line is filled.
- R2: A request accepted at a clock edge produces `rsp_valid` high for exactly that one following cycle. With no request, `rsp_valid` is low.
- R3: The translation buffer matches bits [31:12] of the address against all valid entries. On a match, `rsp_tlb_miss` is 0 and `rsp_paddr` is {frame, bits [11:0]}. With no match, `rsp_tlb_miss` is 1 and `rsp_paddr` is {20'h0, bits [11:0]}.
- R4: The cache line is chosen by bits [11:2] of the virtual address. `rsp_hit` is 1 only when that line is valid and its stored tag equals the translated frame. On a hit, `rsp_word` is the line's 32-bit data.
- R5: Two virtual pages mapped to the same frame hit the same cache line. A valid line whose tag differs from the frame reports a miss.
- R6: On a translation miss, `rsp_hit` is 0, even when the indexed line is valid with tag 0.
- R7: `rsp_byte` is byte k of `rsp_word`, where k = bits [1:0] of the request address, in little-endian order (byte k is word bits [8k+7:8k]).
- R8: Translation fills go to entries in round-robin order, starting at entry 0 after reset. The ninth fill replaces the first entry loaded, and the tenth fill replaces the second.
- R9: A cache fill writes tag and data at the given index and marks the line valid. Filling a line again replaces its previous contents.
- R10: A lookup and a fill (of either kind) are never presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to look up |
| tfill_en | input | 1 | Load one translation entry |
| tfill_vpn | input | 20 | Virtual page number of the new entry |
| tfill_pfn | input | 20 | Physical frame number of the new entry |
| cfill_en | input | 1 | Write one cache line |
| cfill_index | input | 10 | Cache line index to write |
| cfill_ptag | input | 20 | Physical frame tag for the line |
| cfill_word | input | 32 | Data word for the line |
| rsp_valid | output | 1 | Lookup result present |
| rsp_tlb_miss | output | 1 | No translation entry matched |
| rsp_hit | output | 1 | Translation hit and cache tag match |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_word | output | 32 | Cache line data (meaningful on hit) |
| rsp_byte | output | 8 | Byte selected by address bits [1:0] |

## Verification
The bench probes an unmapped page whose cache index holds a valid line tagged zero. A design that compared against a cleared frame register would report a false hit there. Two virtual pages aliasing one frame must both hit one line, and a frame mismatch on a valid line must miss. These cases catch a cache tagged with virtual bits, or one whose tag compare is skipped. Ten translation fills into eight entries show whether the pointer wraps to the oldest entry, rather than sticking or overwriting the newest. A reset taken in mid-run followed by a translation refill shows whether the cache valid bits were really cleared. Byte selection at every lane exposes swapped endianness.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_BITS    = 32;
  localparam int PAGE_BITS  = 12;
  localparam int FRAME_BITS = 20;
  localparam int WORD_BYTES = 4;
  localparam int TLB_SLOTS  = 8;

  function automatic logic [7:0] pick_byte(input logic [WORD_BYTES*8-1:0] w,
                                           input logic [$clog2(WORD_BYTES)-1:0] lane);
    return w[lane*8 +: 8];
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PFN_W-1:0] look_pfn
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slot_vld;
  logic [VPN_W-1:0] slot_vpn [DEPTH];
  logic [PFN_W-1:0] slot_pfn [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      wr_ptr   <= '0;
    end else if (fill_en) begin
      slot_vld[wr_ptr] <= 1'b1;
      slot_vpn[wr_ptr] <= fill_vpn;
      slot_pfn[wr_ptr] <= fill_pfn;
      wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = slot_vld[i] && (slot_vpn[i] == look_vpn);
  end

  always_comb begin
    look_pfn = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) look_pfn = slot_pfn[i];
    end
  end

  assign look_hit = |match;
endmodule

// File: rtl/dcache_ram.sv
module dcache_ram #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int ROW_W = TAG_W + DATA_W;

  logic [ROW_W-1:0] mem [LINES];
  logic [ROW_W-1:0] row_q;
  logic [LINES-1:0] line_vld;

  // tag+data array: no reset, sync read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_data};
    if (rd_en) row_q <= mem[rd_idx];
  end

  // valid bits kept in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      line_vld <= '0;
      rd_vld   <= 1'b0;
    end else begin
      if (wr_en) line_vld[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= line_vld[rd_idx];
    end
  end

  assign rd_tag  = row_q[ROW_W-1:DATA_W];
  assign rd_data = row_q[DATA_W-1:0];
endmodule

// File: rtl/xlat_dcache_lookup.sv
module xlat_dcache_lookup
  import xlat_pkg::*;
#(
  parameter int VA_W  = VA_BITS,
  parameter int OFF_W = PAGE_BITS,
  parameter int PFN_W = FRAME_BITS,
  parameter int WB    = WORD_BYTES,
  parameter int TLB_N = TLB_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   tfill_en,
  input  logic [VA_W-OFF_W-1:0]  tfill_vpn,
  input  logic [PFN_W-1:0]       tfill_pfn,
  input  logic                   cfill_en,
  input  logic [OFF_W-$clog2(WB)-1:0] cfill_index,
  input  logic [PFN_W-1:0]       cfill_ptag,
  input  logic [8*WB-1:0]        cfill_word,
  output logic                   rsp_valid,
  output logic                   rsp_tlb_miss,
  output logic                   rsp_hit,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [8*WB-1:0]        rsp_word,
  output logic [7:0]             rsp_byte
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int LANE_W = $clog2(WB);
  localparam int IDX_W  = OFF_W - LANE_W;
  localparam int DATA_W = 8 * WB;

  logic             xl_hit;
  logic [PFN_W-1:0] xl_pfn;
  logic             line_vld;
  logic [PFN_W-1:0] line_tag;
  logic [DATA_W-1:0] line_data;

  logic             vld_q;
  logic             xl_hit_q;
  logic [PFN_W-1:0] pfn_q;
  logic [OFF_W-1:0] off_q;

  tlb_cam #(.VPN_W(VPN_W), .PFN_W(PFN_W), .DEPTH(TLB_N)) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .fill_en  (tfill_en),
    .fill_vpn (tfill_vpn),
    .fill_pfn (tfill_pfn),
    .look_vpn (req_vaddr[VA_W-1:OFF_W]),
    .look_hit (xl_hit),
    .look_pfn (xl_pfn)
  );

  // index from untranslated offset bits: read starts alongside translation
  dcache_ram #(.IDX_W(IDX_W), .TAG_W(PFN_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfill_en),
    .wr_idx  (cfill_index),
    .wr_tag  (cfill_ptag),
    .wr_data (cfill_word),
    .rd_en   (req_valid),
    .rd_idx  (req_vaddr[OFF_W-1:LANE_W]),
    .rd_vld  (line_vld),
    .rd_tag  (line_tag),
    .rd_data (line_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= 1'b0;
      xl_hit_q <= 1'b0;
      pfn_q    <= '0;
      off_q    <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        xl_hit_q <= xl_hit;
        pfn_q    <= xl_hit ? xl_pfn : '0;
        off_q    <= req_vaddr[OFF_W-1:0];
      end
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_tlb_miss = vld_q && !xl_hit_q;
  assign rsp_hit      = vld_q && xl_hit_q && line_vld && (line_tag == pfn_q);
  assign rsp_paddr    = {pfn_q, off_q};
  assign rsp_word     = line_data;
  assign rsp_byte     = line_data[off_q[LANE_W-1:0]*8 +: 8];
endmodule

// File: rtl/xlat_lookup_chk.sv
module xlat_lookup_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic [VA_W-1:0]        req_vaddr,
  input logic                   tfill_en,
  input logic                   cfill_en,
  input logic                   rsp_valid,
  input logic                   rsp_tlb_miss,
  input logic                   rsp_hit,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr
);
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_offset_passthru_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_tlb_miss) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_miss_blocks_hit_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_tlb_miss |-> !rsp_hit);

  p_hit_only_valid_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  p_no_fill_with_req_r10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && (tfill_en || cfill_en)));
endmodule

bind xlat_dcache_lookup xlat_lookup_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .tfill_en     (tfill_en),
  .cfill_en     (cfill_en),
  .rsp_valid    (rsp_valid),
  .rsp_tlb_miss (rsp_tlb_miss),
  .rsp_hit      (rsp_hit),
  .rsp_paddr    (rsp_paddr)
);

// File: tb/sim_xlat_dcache_lookup.sv
`timescale 1ns/1ps
module sim_xlat_dcache_lookup;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        tfill_en = 1'b0;
  logic [19:0] tfill_vpn = '0;
  logic [19:0] tfill_pfn = '0;
  logic        cfill_en = 1'b0;
  logic [9:0]  cfill_index = '0;
  logic [19:0] cfill_ptag = '0;
  logic [31:0] cfill_word = '0;
  logic        rsp_valid, rsp_tlb_miss, rsp_hit;
  logic [31:0] rsp_paddr, rsp_word;
  logic [7:0]  rsp_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  xlat_dcache_lookup u0 (.*);

  typedef struct packed {
    logic [31:0] va;
    logic        tmiss;
    logic        hit;
    logic [31:0] pa;
    logic [31:0] word;
    logic [7:0]  by;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h12345014, 1'b0, 1'b1, 32'hABCDE014, 32'h11223344, 8'h44}, // R4 R7 lane0
    '{32'h12345017, 1'b0, 1'b1, 32'hABCDE017, 32'h11223344, 8'h11}, // R7 lane3
    '{32'h00010FFE, 1'b0, 1'b1, 32'h00777FFE, 32'hCAFEF00D, 8'hFE}, // R4 R7 lane2
    '{32'h00020FFD, 1'b0, 1'b1, 32'h00777FFD, 32'hCAFEF00D, 8'hF0}, // R5 alias lane1
    '{32'h00000040, 1'b1, 1'b0, 32'h00000040, 32'h0,        8'h0},  // R6 tag-0 line
    '{32'h7FFFF080, 1'b0, 1'b0, 32'h00001080, 32'h0,        8'h0},  // R5 tag mismatch
    '{32'h12345800, 1'b0, 1'b0, 32'hABCDE800, 32'h0,        8'h0},  // R4 invalid line
    '{32'h99999000, 1'b1, 1'b0, 32'h00000000, 32'h0,        8'h0}   // R3 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tfill(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk); tfill_en = 1'b1; tfill_vpn = v; tfill_pfn = p;
    @(negedge clk); tfill_en = 1'b0;
  endtask

  task automatic cfill(input logic [9:0] i, input logic [19:0] t, input logic [31:0] w);
    @(negedge clk); cfill_en = 1'b1; cfill_index = i; cfill_ptag = t; cfill_word = w;
    @(negedge clk); cfill_en = 1'b0;
  endtask

  // drive request at negedge; result registered at next posedge; sample at following negedge
  task automatic look(input logic [31:0] va);
    @(negedge clk); req_valid = 1'b1; req_vaddr = va;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    look(32'h12345014);
    chk("R1 empty tlb misses", {31'b0, rsp_tlb_miss}, 32'd1);
    chk("R1 no hit after reset", {31'b0, rsp_hit}, 32'd0);
    @(negedge clk);
    chk("R2 valid drops without request", {31'b0, rsp_valid}, 32'd0);

    tfill(20'h12345, 20'hABCDE);
    tfill(20'h00010, 20'h00777);
    tfill(20'h00020, 20'h00777);
    tfill(20'h7FFFF, 20'h00001);
    cfill(10'h005, 20'hABCDE, 32'h11223344);
    cfill(10'h3FF, 20'h00777, 32'hCAFEF00D);
    cfill(10'h010, 20'h00000, 32'hDEADBEEF);
    cfill(10'h020, 20'h00002, 32'h00000055);

    for (int k = 0; k < NV; k++) begin
      look(VEC[k].va);
      chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
      chk("R3 tlb miss flag", {31'b0, rsp_tlb_miss}, {31'b0, VEC[k].tmiss});
      chk("R4/R5/R6 hit flag", {31'b0, rsp_hit}, {31'b0, VEC[k].hit});
      chk("R3 physical address", rsp_paddr, VEC[k].pa);
      if (VEC[k].hit) begin
        chk("R4 word", rsp_word, VEC[k].word);
        chk("R7 byte lane", {24'b0, rsp_byte}, {24'b0, VEC[k].by});
      end
    end

    // R8: round-robin fill from entry 0
    do_reset();
    for (int i = 0; i < 10; i++)
      tfill(20'h00100 + 20'(i), (i < 8) ? 20'h00200 + 20'(i) : 20'h00300 + 20'(i));
    look(32'h00100000);
    chk("R8 ninth fill evicted first entry", {31'b0, rsp_tlb_miss}, 32'd1);
    look(32'h00101000);
    chk("R8 tenth fill evicted second entry", {31'b0, rsp_tlb_miss}, 32'd1);
    look(32'h00102ABC);
    chk("R8 third entry kept", rsp_paddr, 32'h00202ABC);
    look(32'h00108004);
    chk("R8 ninth entry present", rsp_paddr, 32'h00308004);
    look(32'h00109FFF);
    chk("R8 tenth entry present", rsp_paddr, 32'h00309FFF);

    // R1: valid bits cleared by reset; R9: refill replaces line
    do_reset();
    tfill(20'h12345, 20'hABCDE);
    look(32'h12345014);
    chk("R1 tlb refilled", {31'b0, rsp_tlb_miss}, 32'd0);
    chk("R1 cache valid cleared", {31'b0, rsp_hit}, 32'd0);
    cfill(10'h005, 20'h0BEEF, 32'h01020304);
    look(32'h12345014);
    chk("R9 wrong tag misses", {31'b0, rsp_hit}, 32'd0);
    cfill(10'h005, 20'hABCDE, 32'h99887766);
    look(32'h12345015);
    chk("R9 refill hits", {31'b0, rsp_hit}, 32'd1);
    chk("R9 refill data", rsp_word, 32'h99887766);
    chk("R7 lane1 after refill", {24'b0, rsp_byte}, 32'h00000077);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule